// File: doc/BRIEF.md
# Sigma-delta converter parallel bus interface

This block is the device-side digital front of a 24-bit converter that shares a 16-bit bidirectional parallel bus with a host. An internal data port hands it each finished conversion result (24-bit two's complement) together with an 8-bit status byte. The block announces each result with a one-cycle active-low ready strobe and serves it to the host as two consecutive 16-bit read words. It also decodes two-phase register writes into a small control register file. A write consists of an address word followed by a data word, and each phase must hold chip select low long enough. All logic runs on the internal converter clock. The tri-state bus is modelled as a separate input word, output word and output enable.

Reads are tracked by a four-state read machine: `RD_HI_NEXT` (the next read serves the upper word), `RD_HI_BUSY` (upper word on the bus), `RD_LO_NEXT` (the next read serves the lower word) and `RD_LO_BUSY` (lower word on the bus). The machine moves `RD_HI_NEXT -> RD_HI_BUSY` when a read starts, and takes a snapshot of the pending result at that step. It then moves `RD_HI_BUSY -> RD_LO_NEXT` when the read ends, `RD_LO_NEXT -> RD_LO_BUSY` when the next read starts, and `RD_LO_BUSY -> RD_HI_NEXT` when that read ends.

Writes are tracked by a four-state write machine: `WR_ADDR_IDLE`, `WR_ADDR_LOW`, `WR_DATA_IDLE` and `WR_DATA_LOW`. A write strobe moves `*_IDLE -> *_LOW`. The release of the strobe leads to one of two outcomes. A long enough `WR_ADDR_LOW` goes to `WR_DATA_IDLE`, and a long enough `WR_DATA_LOW` goes to `WR_ADDR_IDLE`, committing the write. A strobe that was too short returns to the idle state of the same phase.

Top module: `adc_pbus_if`

## Requirements
- R1: After reset `drdy_n` is 1, `bus_oe` is 0, every control register reads 0, and the first read returns the upper word of a result.
- R2: A cycle with `res_valid` high stores the result and status, and drives `drdy_n` low for exactly the following cycle.
- R3: The first read of a pair returns result bits [23:8]. The second read returns {result bits [7:0], status byte}, with the status byte in bits [7:0] unchanged. In that byte, bit 7 is the download-checksum match, bit 6 is the filter-checksum match, and the remaining bits include the overrange flag.
- R4: If a new result arrives between the two reads of a pair, the second read still returns the low byte and status of the result whose upper word was read. The next pair returns the new result.
- R5: A read is chip select low with `rw` low. `bus_oe` rises one cycle after a read begins and falls one cycle after chip select rises. It is never high for a write strobe.
- R6: An address phase with chip select low and `rw` high for at least MIN_LO (4) cycles latches the last sampled bus word as the address. A following data phase of at least MIN_LO cycles writes its bus word to that register, and the new value is visible on `ctrl_regs` in the cycle after chip select is seen high. Register k occupies `ctrl_regs[16k+15:16k]`.
- R7: An address phase shorter than MIN_LO cycles is ignored: no address is latched, and the next phase is still taken as an address phase.
- R8: A data phase shorter than MIN_LO cycles is ignored: no register changes, and the next phase is still taken as the data phase.
- R9: A write to an address of N_REGS (4) or above changes no register, and the machine then expects a new address phase.
- R10: `low_pwr` reflects bit 2 of register 0, and `pwr_down` reflects bit 3 of register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal converter clock |
| rst_n | input | 1 | Active-low reset |
| res_valid | input | 1 | New result present on the internal data port |
| res_data | input | 24 | Conversion result, two's complement |
| res_stat | input | 8 | Status byte accompanying the result |
| drdy_n | output | 1 | Active-low result-ready strobe |
| cs_n | input | 1 | Active-low chip select |
| rw | input | 1 | 0 = read, 1 = write while chip select is low |
| bus_in | input | 16 | Word driven onto the bus by the host |
| bus_out | output | 16 | Word the block drives onto the bus |
| bus_oe | output | 1 | Bus output enable |
| ctrl_regs | output | 64 | Control register file, register k in bits [16k+15:16k] |
| pwr_down | output | 1 | Power-down control bit (reg 0 bit 3) |
| low_pwr | output | 1 | Low-power mode control bit (reg 0 bit 2) |

## Verification
The bench builds the block with its default values: MIN_LO = 4 and N_REGS = 4. With MIN_LO = 4, a three-cycle strobe and a four-cycle strobe sit on either side of the acceptance limit, in both the address phase and the data phase. With N_REGS = 4, address 4 is the first out-of-range address, so every legal register and the first illegal one are all reachable with short sequences. Result pairs are read both undisturbed and with a fresh result arriving between the upper and lower word.

// File: rtl/adc_pbus_pkg.sv
package adc_pbus_pkg;

    typedef enum logic [1:0] {
        RD_HI_NEXT,
        RD_HI_BUSY,
        RD_LO_NEXT,
        RD_LO_BUSY
    } rd_state_t;

    typedef enum logic [1:0] {
        WR_ADDR_IDLE,
        WR_ADDR_LOW,
        WR_DATA_IDLE,
        WR_DATA_LOW
    } wr_state_t;

    // control bit positions inside register 0
    localparam int unsigned LP_BIT = 2;
    localparam int unsigned PD_BIT = 3;

endpackage

// File: rtl/adc_rd_path.sv
module adc_rd_path
    import adc_pbus_pkg::*;
#(
    parameter int unsigned RES_W  = 24,
    parameter int unsigned BUS_W  = 16,
    parameter int unsigned STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [RES_W-1:0]  res_data,
    input  logic [STAT_W-1:0] res_stat,
    input  logic              cs_n,
    input  logic              rw,
    output logic              drdy_n,
    output logic [BUS_W-1:0]  bus_out,
    output logic              bus_oe
);

    localparam int unsigned LOW_W = RES_W - BUS_W;

    rd_state_t         state;
    rd_state_t         state_nxt;
    logic [RES_W-1:0]  pend_data;
    logic [STAT_W-1:0] pend_stat;
    logic [LOW_W-1:0]  snap_low;
    logic [STAT_W-1:0] snap_stat;
    logic              rd_act;

    assign rd_act = !cs_n && !rw;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RD_HI_NEXT;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            RD_HI_NEXT: if (rd_act)  state_nxt = RD_HI_BUSY;
            RD_HI_BUSY: if (!rd_act) state_nxt = RD_LO_NEXT;
            RD_LO_NEXT: if (rd_act)  state_nxt = RD_LO_BUSY;
            RD_LO_BUSY: if (!rd_act) state_nxt = RD_HI_NEXT;
        endcase
    end

    // outputs and data holding
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_data <= '0;
            pend_stat <= '0;
            snap_low  <= '0;
            snap_stat <= '0;
            drdy_n    <= 1'b1;
            bus_out   <= '0;
            bus_oe    <= 1'b0;
        end else begin
            drdy_n <= !res_valid;
            bus_oe <= rd_act;
            if (res_valid) begin
                pend_data <= res_data;
                pend_stat <= res_stat;
            end
            if (state == RD_HI_NEXT && rd_act) begin
                bus_out   <= pend_data[RES_W-1 -: BUS_W];
                snap_low  <= pend_data[LOW_W-1:0];
                snap_stat <= pend_stat;
            end else if (state == RD_LO_NEXT && rd_act) begin
                bus_out <= {snap_low, snap_stat};
            end
        end
    end

    AST_DRDY_FROM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drdy_n) |-> $past(res_valid)); // R2

    AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_LO_NEXT) |=> ($stable(snap_low) && $stable(snap_stat))); // R4

    AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> $past(!cs_n && !rw)); // R5

endmodule

// File: rtl/adc_wr_path.sv
module adc_wr_path
    import adc_pbus_pkg::*;
#(
    parameter int unsigned BUS_W  = 16,
    parameter int unsigned N_REGS = 4,
    parameter int unsigned MIN_LO = 4,
    localparam int unsigned IDX_W = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rw,
    input  logic [BUS_W-1:0] bus_in,
    output logic             we,
    output logic [IDX_W-1:0] waddr,
    output logic [BUS_W-1:0] wdata
);

    localparam int unsigned CNT_W = $clog2(MIN_LO + 1);

    wr_state_t        state;
    wr_state_t        state_nxt;
    logic [CNT_W-1:0] cnt;
    logic [BUS_W-1:0] shadow;
    logic [BUS_W-1:0] addr_q;
    logic             wr_act;
    logic             long_enough;
    logic             addr_ok;

    assign wr_act      = !cs_n && rw;
    assign long_enough = (cnt >= CNT_W'(MIN_LO));
    assign addr_ok     = (addr_q < BUS_W'(N_REGS));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WR_ADDR_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            WR_ADDR_IDLE: if (wr_act) state_nxt = WR_ADDR_LOW;
            WR_ADDR_LOW:  if (!wr_act) state_nxt = long_enough ? WR_DATA_IDLE : WR_ADDR_IDLE;
            WR_DATA_IDLE: if (wr_act) state_nxt = WR_DATA_LOW;
            WR_DATA_LOW:  if (!wr_act) state_nxt = long_enough ? WR_ADDR_IDLE : WR_DATA_IDLE;
        endcase
    end

    // outputs: strobe length, captured words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            shadow <= '0;
            addr_q <= '0;
        end else begin
            if (wr_act) begin
                shadow <= bus_in;
                if (state == WR_ADDR_IDLE || state == WR_DATA_IDLE) begin
                    cnt <= CNT_W'(1);
                end else if (!long_enough) begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
            if (state == WR_ADDR_LOW && !wr_act && long_enough) begin
                addr_q <= shadow;
            end
        end
    end

    assign we    = (state == WR_DATA_LOW) && !wr_act && long_enough && addr_ok;
    assign waddr = addr_q[IDX_W-1:0];
    assign wdata = shadow;

    AST_ADDR_NEEDS_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WR_DATA_IDLE && $past(state) == WR_ADDR_LOW) |-> $past(cnt) >= CNT_W'(MIN_LO)); // R7

    AST_WE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (cs_n || !rw) && $past(!cs_n && rw)); // R6

endmodule

// File: rtl/adc_reg_file.sv
module adc_reg_file #(
    parameter int unsigned BUS_W  = 16,
    parameter int unsigned N_REGS = 4,
    localparam int unsigned IDX_W = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [IDX_W-1:0]        waddr,
    input  logic [BUS_W-1:0]        wdata,
    output logic [N_REGS*BUS_W-1:0] regs_flat
);

    logic [BUS_W-1:0] regs [N_REGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_REGS; i++) begin
                regs[i] <= '0;
            end
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < N_REGS; g++) begin : g_flat
        assign regs_flat[g*BUS_W +: BUS_W] = regs[g];
    end

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs_flat)); // R8

endmodule

// File: rtl/adc_pbus_if.sv
module adc_pbus_if
    import adc_pbus_pkg::*;
#(
    parameter int unsigned RES_W  = 24,
    parameter int unsigned BUS_W  = 16,
    parameter int unsigned STAT_W = 8,
    parameter int unsigned N_REGS = 4,
    parameter int unsigned MIN_LO = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    res_valid,
    input  logic [RES_W-1:0]        res_data,
    input  logic [STAT_W-1:0]       res_stat,
    output logic                    drdy_n,
    input  logic                    cs_n,
    input  logic                    rw,
    input  logic [BUS_W-1:0]        bus_in,
    output logic [BUS_W-1:0]        bus_out,
    output logic                    bus_oe,
    output logic [N_REGS*BUS_W-1:0] ctrl_regs,
    output logic                    pwr_down,
    output logic                    low_pwr
);

    localparam int unsigned IDX_W = (N_REGS > 1) ? $clog2(N_REGS) : 1;

    logic             we;
    logic [IDX_W-1:0] waddr;
    logic [BUS_W-1:0] wdata;

    adc_rd_path #(
        .RES_W  (RES_W),
        .BUS_W  (BUS_W),
        .STAT_W (STAT_W)
    ) i_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .res_data  (res_data),
        .res_stat  (res_stat),
        .cs_n      (cs_n),
        .rw        (rw),
        .drdy_n    (drdy_n),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe)
    );

    adc_wr_path #(
        .BUS_W  (BUS_W),
        .N_REGS (N_REGS),
        .MIN_LO (MIN_LO)
    ) i_wr (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .rw     (rw),
        .bus_in (bus_in),
        .we     (we),
        .waddr  (waddr),
        .wdata  (wdata)
    );

    adc_reg_file #(
        .BUS_W  (BUS_W),
        .N_REGS (N_REGS)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (we),
        .waddr     (waddr),
        .wdata     (wdata),
        .regs_flat (ctrl_regs)
    );

    assign low_pwr  = ctrl_regs[LP_BIT];
    assign pwr_down = ctrl_regs[PD_BIT];

    AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !bus_oe); // R5

endmodule

// File: tb/test_adc_pbus_if.sv
module test_adc_pbus_if;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [23:0] res_data = '0;
    logic [7:0]  res_stat = '0;
    logic        drdy_n;
    logic        cs_n = 1'b1;
    logic        rw = 1'b0;
    logic [15:0] bus_in = '0;
    logic [15:0] bus_out;
    logic        bus_oe;
    logic [63:0] ctrl_regs;
    logic        pwr_down;
    logic        low_pwr;

    int checks = 0;
    int errors = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] exp_regs [4];
    logic        oe_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_pbus_if i_adc_pbus_if (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .res_data  (res_data),
        .res_stat  (res_stat),
        .drdy_n    (drdy_n),
        .cs_n      (cs_n),
        .rw        (rw),
        .bus_in    (bus_in),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe),
        .ctrl_regs (ctrl_regs),
        .pwr_down  (pwr_down),
        .low_pwr   (low_pwr)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: compares every newly driven bus word against the scoreboard
    always @(negedge clk) begin
        if (rst_n && bus_oe && !oe_prev) begin
            if (exp_q.size() == 0) begin
                check("R5 unexpected bus drive", 64'(bus_out), 64'hX);
            end else begin
                check(tag_q.pop_front(), 64'(bus_out), 64'(exp_q.pop_front()));
            end
        end
        oe_prev = bus_oe;
    end

    task automatic push_result(logic [23:0] d, logic [7:0] s);
        res_data  = d;
        res_stat  = s;
        res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic read_word(logic [15:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        cs_n = 1'b0;
        rw   = 1'b0;
        @(negedge clk);
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        check("R5 bus released after read", 64'(bus_oe), 64'd0);
    endtask

    task automatic write_phase(logic [15:0] val, int n);
        cs_n   = 1'b0;
        rw     = 1'b1;
        bus_in = val;
        repeat (n) @(negedge clk);
        cs_n   = 1'b1;
        rw     = 1'b0;
        bus_in = '0;
        @(negedge clk);
    endtask

    function automatic logic [63:0] regs_model();
        return {exp_regs[3], exp_regs[2], exp_regs[1], exp_regs[0]};
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) exp_regs[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 drdy_n idle", 64'(drdy_n), 64'd1);
        check("R1 bus_oe idle", 64'(bus_oe), 64'd0);
        check("R1 regs cleared", ctrl_regs, 64'd0);
        check("R1 power bits", {62'd0, pwr_down, low_pwr}, 64'd0);

        // R2 ready strobe
        res_data  = 24'hABCDEF;
        res_stat  = 8'hC5;
        res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
        check("R2 drdy_n pulse low", 64'(drdy_n), 64'd0);
        @(negedge clk);
        check("R2 drdy_n back high", 64'(drdy_n), 64'd1);

        // R1/R3 first pair after reset
        read_word(16'hABCD, "R3 upper word (R1 first read)");
        read_word(16'hEFC5, "R3 lower byte with status");

        // R4 new result inside a pair
        push_result(24'h123456, 8'h81);
        read_word(16'h1234, "R4 upper word of old result");
        push_result(24'h789ABC, 8'h40);
        read_word(16'h5681, "R4 lower word keeps old result");
        read_word(16'h789A, "R4 next pair upper word new");
        read_word(16'hBC40, "R4 next pair lower word new");

        // R5 write strobe never enables the bus
        cs_n = 1'b0;
        rw   = 1'b1;
        @(negedge clk);
        check("R5 no drive on write strobe", 64'(bus_oe), 64'd0);
        cs_n = 1'b1;
        rw   = 1'b0;
        @(negedge clk);

        // R6 basic writes, R10 decoded bits
        write_phase(16'h0000, 4);
        write_phase(16'hA55A, 4);
        exp_regs[0] = 16'hA55A;
        check("R6 reg0 write", ctrl_regs, regs_model());
        check("R10 pwr_down from bit3", 64'(pwr_down), 64'd1);
        check("R10 low_pwr from bit2", 64'(low_pwr), 64'd0);
        write_phase(16'h0002, 6);
        write_phase(16'h1234, 6);
        exp_regs[2] = 16'h1234;
        check("R6 reg2 long phases", ctrl_regs, regs_model());

        // R7 short address phase ignored
        write_phase(16'h0001, 3);
        check("R7 nothing written by short addr", ctrl_regs, regs_model());
        write_phase(16'h0001, 4);
        write_phase(16'h0004, 4);
        exp_regs[1] = 16'h0004;
        check("R7 following phase taken as address", ctrl_regs, regs_model());

        // R8 short data phase ignored
        write_phase(16'h0003, 4);
        write_phase(16'hFFFF, 3);
        check("R8 short data ignored", ctrl_regs, regs_model());
        write_phase(16'h0BEE, 4);
        exp_regs[3] = 16'h0BEE;
        check("R8 next phase is data", ctrl_regs, regs_model());

        // R9 out-of-range address
        write_phase(16'h0004, 4);
        write_phase(16'hDEAD, 4);
        check("R9 out-of-range write ignored", ctrl_regs, regs_model());
        write_phase(16'h0000, 4);
        write_phase(16'h0004, 4);
        exp_regs[0] = 16'h0004;
        check("R9 address phase expected after", ctrl_regs, regs_model());
        check("R10 low_pwr set", 64'(low_pwr), 64'd1);
        check("R10 pwr_down clear", 64'(pwr_down), 64'd0);

        // R3 reads still in order after writes
        push_result(24'hF00F11, 8'h3C);
        read_word(16'hF00F, "R3 upper word after writes");
        read_word(16'h113C, "R3 lower word after writes");

        repeat (2) @(negedge clk);
        check("R3 all expected words seen", 64'(exp_q.size()), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule